// File: doc/BRIEF.md
# Per-Thread Reorder Occupancy Limiter

This block keeps the occupancy bookkeeping for a reorder buffer that several hardware threads share. It stores no instructions. It counts how many entries each thread holds and how many the whole buffer holds. From a static sharing policy and the set of currently active threads, it derives a ceiling for every thread. The dispatch stage reads a free-entry figure for each thread and one global free-entry figure, and stalls a thread when its figure reaches zero.

Allocation and retirement arrive as single-cycle pulses tagged with a thread number. The block refuses an allocation that has no room, leaves the counts alone, and flags the refusal one cycle later. Three sharing policies are supported:
- every thread may use the whole buffer;
- the buffer is split evenly across threads;
- every thread is held to a programmed threshold.

Ceilings follow the active-thread mask. When a ceiling drops below a thread's current occupancy, the block evicts nothing: that thread's free figure stays at zero until enough of its entries retire.

Top module: `rob_share_limiter`

## Requirements
- R1: While `rst` is high at a clock edge, all occupancy counts clear. After that edge `global_free` equals CAPACITY, `alloc_reject` is 0, and every thread's free field equals its ceiling for the current configuration.
- R2: With `cfg_policy` = 2'b00 (shared), every thread's ceiling is CAPACITY.
- R3: With `cfg_policy` = 2'b01 (even split), each active thread's ceiling is CAPACITY divided by the number of active threads, rounded down. An inactive thread gets CAPACITY/NT, and so does every thread when the mask is all zero.
- R4: With `cfg_policy` = 2'b10 (threshold), every thread's ceiling is `cfg_threshold` clamped to CAPACITY. When exactly one thread is active, that thread's ceiling is CAPACITY instead.
- R5: `cfg_policy` = 2'b11 is illegal. It makes every ceiling zero, so every allocation is refused.
- R6: Thread t's free field is `thread_free[t*CW +: CW]`, where CW = $clog2(CAPACITY+1). It equals ceiling minus occupancy, saturated at zero, and reflects the inputs sampled at the previous clock edge.
- R7: `global_free` equals CAPACITY minus the total occupancy of all threads.
- R8: An allocation is refused when the tagged thread's free field is zero or `global_free` is zero. A refused allocation changes no count, and `alloc_reject` is 1 in the following cycle only.
- R9: An accepted allocation and a retirement for the same thread in one cycle leave that thread's occupancy and the total unchanged. A retirement for a thread with zero occupancy is ignored.
- R10: When a ceiling falls below a thread's occupancy, the thread keeps its entries and its free field reads zero. Later retirements lower the occupancy until free space reappears.
- R11: A change of `active_mask` or of the configuration shows up in the free fields one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_policy | input | 2 | Sharing policy: 00 shared, 01 even split, 10 threshold, 11 illegal |
| cfg_threshold | input | CW | Per-thread ceiling used in threshold mode |
| active_mask | input | NT | One bit per thread that is currently running |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_tid | input | TW | Thread tag of the allocation |
| retire_valid | input | 1 | One entry retires |
| retire_tid | input | TW | Thread tag of the retirement |
| thread_free | output | NT*CW | Free-entry figure per thread, thread t at bits t*CW +: CW |
| global_free | output | CW | Free entries in the whole buffer |
| alloc_reject | output | 1 | Pulses the cycle after a refused allocation |

## Verification
An allocation and a retirement can land in the same cycle, either on the same thread or on different threads. The bench provokes this in directed steps and in a long random phase that keeps changing the policy and the active mask. A reference model in the bench applies the acceptance rule to the state before the edge and then updates its counts. It compares every free field, the global figure and the reject flag on every clock. The hardest case is a same-cycle allocation and retirement on a thread whose free figure is already zero: the allocation must be refused and the retirement must still take effect.

// File: rtl/rob_share_pkg.sv
package rob_share_pkg;
  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_THRESH = 2'd2,
    POL_BAD    = 2'd3
  } share_pol_e;
endpackage

// File: rtl/rob_limit_calc.sv
module rob_limit_calc #(
  parameter int NT       = 4,
  parameter int CAPACITY = 32,
  parameter int CW       = $clog2(CAPACITY + 1)
) (
  input  logic [1:0]              policy,
  input  logic [CW-1:0]           thresh,
  input  logic [NT-1:0]           active,
  output logic [NT-1:0][CW-1:0]   limit
);
  import rob_share_pkg::*;

  localparam int AW = $clog2(NT + 1);
  localparam logic [CW-1:0] CAP_W  = CW'(CAPACITY);
  localparam logic [CW-1:0] BASE_W = CW'(CAPACITY / NT);

  // Even share for k active threads; each quotient is an elaboration-time constant.
  function automatic logic [CW-1:0] share_of(input logic [AW-1:0] k);
    logic [CW-1:0] s;
    s = BASE_W;
    for (int j = 1; j <= NT; j++) begin
      if (k == AW'(j)) s = CW'(CAPACITY / j);
    end
    return s;
  endfunction

  logic [AW-1:0] n_act;
  logic [CW-1:0] thr_c;
  logic [CW-1:0] split_w;
  share_pol_e    pol;

  always_comb begin
    n_act = '0;
    for (int t = 0; t < NT; t++) n_act = n_act + AW'(active[t]);
  end

  assign thr_c   = (thresh > CAP_W) ? CAP_W : thresh;
  assign split_w = share_of(n_act);
  assign pol     = share_pol_e'(policy);

  for (genvar t = 0; t < NT; t++) begin : g_lim
    always_comb begin
      unique case (pol)
        POL_SHARED: limit[t] = CAP_W;
        POL_SPLIT:  limit[t] = (active[t] && n_act != '0) ? split_w : BASE_W;
        POL_THRESH: limit[t] = (active[t] && n_act == AW'(1)) ? CAP_W : thr_c;
        default:    limit[t] = '0;
      endcase
    end
  end
endmodule

// File: rtl/rob_thread_ctr.sv
module rob_thread_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] limit_nxt,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] free_q
);
  logic [CW-1:0] count_nxt;

  assign count_nxt = count_q + CW'(inc) - CW'(dec);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      free_q  <= limit_nxt;
    end else begin
      count_q <= count_nxt;
      free_q  <= (limit_nxt > count_nxt) ? (limit_nxt - count_nxt) : '0;
    end
  end
endmodule

// File: rtl/rob_share_limiter.sv
module rob_share_limiter #(
  parameter int NT       = 4,
  parameter int CAPACITY = 32,
  parameter int CW       = $clog2(CAPACITY + 1),
  parameter int TW       = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_policy,
  input  logic [CW-1:0]     cfg_threshold,
  input  logic [NT-1:0]     active_mask,
  input  logic              alloc_valid,
  input  logic [TW-1:0]     alloc_tid,
  input  logic              retire_valid,
  input  logic [TW-1:0]     retire_tid,
  output logic [NT*CW-1:0]  thread_free,
  output logic [CW-1:0]     global_free,
  output logic              alloc_reject
);
  localparam logic [CW-1:0] CAP_W = CW'(CAPACITY);

  logic [NT-1:0][CW-1:0] limit_nxt;
  logic [NT-1:0][CW-1:0] cnt_q;
  logic [NT-1:0][CW-1:0] free_q;
  logic [NT-1:0]         inc_v;
  logic [NT-1:0]         dec_v;
  logic [CW-1:0]         total_q;
  logic [CW-1:0]         total_nxt;
  logic                  alloc_ok;
  logic                  retire_ok;
  logic                  a_in_range;
  logic                  r_in_range;

  rob_limit_calc #(.NT(NT), .CAPACITY(CAPACITY), .CW(CW)) u_limits (
    .policy (cfg_policy),
    .thresh (cfg_threshold),
    .active (active_mask),
    .limit  (limit_nxt)
  );

  assign a_in_range = (32'(alloc_tid)  < NT);
  assign r_in_range = (32'(retire_tid) < NT);

  // Acceptance uses the state before the edge; a same-cycle retire frees no room.
  assign alloc_ok  = alloc_valid && a_in_range &&
                     (free_q[alloc_tid] != '0) && (global_free != '0);
  assign retire_ok = retire_valid && r_in_range && (cnt_q[retire_tid] != '0);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign inc_v[t] = alloc_ok  && (alloc_tid  == TW'(t));
    assign dec_v[t] = retire_ok && (retire_tid == TW'(t));

    rob_thread_ctr #(.CW(CW)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .inc       (inc_v[t]),
      .dec       (dec_v[t]),
      .limit_nxt (limit_nxt[t]),
      .count_q   (cnt_q[t]),
      .free_q    (free_q[t])
    );

    assign thread_free[t*CW +: CW] = free_q[t];
  end

  assign total_nxt = total_q + CW'(alloc_ok) - CW'(retire_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q      <= '0;
      global_free  <= CAP_W;
      alloc_reject <= 1'b0;
    end else begin
      total_q      <= total_nxt;
      global_free  <= CAP_W - total_nxt;
      alloc_reject <= alloc_valid && !alloc_ok;
    end
  end
endmodule

// File: rtl/rob_share_limiter_chk.sv
module rob_share_limiter_chk #(
  parameter int NT       = 4,
  parameter int CAPACITY = 32,
  parameter int CW       = $clog2(CAPACITY + 1),
  parameter int TW       = (NT > 1) ? $clog2(NT) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_policy,
  input logic              alloc_valid,
  input logic [TW-1:0]     alloc_tid,
  input logic              retire_valid,
  input logic [NT*CW-1:0]  thread_free,
  input logic [CW-1:0]     global_free,
  input logic              alloc_reject
);
  logic [CW-1:0] sel_free;
  logic          room;

  assign sel_free = thread_free[32'(alloc_tid)*CW +: CW];
  assign room     = (sel_free != '0) && (global_free != '0);

  // R8: no room means a reject pulse next cycle
  assert_reject_full_R8: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !room) |=> alloc_reject);

  // R8: a request with room is never flagged
  assert_accept_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && room) |=> !alloc_reject);

  // R7: a lone accepted allocation takes exactly one global entry
  assert_global_take_R7: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && room && !retire_valid) |=> (global_free == $past(global_free) - CW'(1)));

  // R9: no traffic leaves the global figure alone
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!alloc_valid && !retire_valid) |=> (global_free == $past(global_free)));

  // R5: illegal policy zeroes every free field
  assert_bad_policy_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_policy == 2'b11) |=> (thread_free == '0));

  // R7: global figure never exceeds capacity
  assert_global_bound_R7: assert property (@(posedge clk) disable iff (rst)
    global_free <= CW'(CAPACITY));
endmodule

bind rob_share_limiter rob_share_limiter_chk #(.NT(NT), .CAPACITY(CAPACITY), .CW(CW), .TW(TW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_policy   (cfg_policy),
  .alloc_valid  (alloc_valid),
  .alloc_tid    (alloc_tid),
  .retire_valid (retire_valid),
  .thread_free  (thread_free),
  .global_free  (global_free),
  .alloc_reject (alloc_reject)
);

// File: tb/tb_rob_share_limiter.sv
`timescale 1ns/1ps
module tb_rob_share_limiter;
  localparam int NT  = 4;
  localparam int CAP = 32;
  localparam int CW  = $clog2(CAP + 1);
  localparam int TW  = $clog2(NT);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cfg_policy = 2'b00;
  logic [CW-1:0]     cfg_threshold = '0;
  logic [NT-1:0]     active_mask = '0;
  logic              alloc_valid = 1'b0;
  logic [TW-1:0]     alloc_tid = '0;
  logic              retire_valid = 1'b0;
  logic [TW-1:0]     retire_tid = '0;
  logic [NT*CW-1:0]  thread_free;
  logic [CW-1:0]     global_free;
  logic              alloc_reject;

  always #10 clk = ~clk;

  rob_share_limiter #(.NT(NT), .CAPACITY(CAP)) dut (
    .clk(clk), .rst(rst), .cfg_policy(cfg_policy), .cfg_threshold(cfg_threshold),
    .active_mask(active_mask), .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
    .retire_valid(retire_valid), .retire_tid(retire_tid),
    .thread_free(thread_free), .global_free(global_free), .alloc_reject(alloc_reject)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_cnt[NT];
  int m_lim[NT];
  int m_total = 0;
  bit m_rej = 0;

  function automatic int ref_limit(int pol, int mask, int thr, int t);
    int n = 0;
    for (int i = 0; i < NT; i++) if ((mask >> i) & 1) n++;
    if (thr > CAP) thr = CAP;
    case (pol)
      0: return CAP;
      1: return (((mask >> t) & 1) && n > 0) ? CAP / n : CAP / NT;
      2: return (((mask >> t) & 1) && n == 1) ? CAP : thr;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_free(int t);
    return (m_lim[t] > m_cnt[t]) ? m_lim[t] - m_cnt[t] : 0;
  endfunction

  task automatic model_edge();
    bit acc;
    bit ret;
    if (rst) begin
      foreach (m_cnt[t]) m_cnt[t] = 0;
      m_total = 0;
      m_rej = 0;
    end else begin
      acc = alloc_valid && ref_free(int'(alloc_tid)) > 0 && (CAP - m_total) > 0;
      ret = retire_valid && m_cnt[int'(retire_tid)] > 0;
      if (acc) begin m_cnt[int'(alloc_tid)]++; m_total++; end
      if (ret) begin m_cnt[int'(retire_tid)]--; m_total--; end
      m_rej = alloc_valid && !acc;
    end
    for (int t = 0; t < NT; t++)
      m_lim[t] = ref_limit(int'(cfg_policy), int'(active_mask), int'(cfg_threshold), t);
  endtask

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    for (int t = 0; t < NT; t++)
      check(req, $sformatf("thread_free[%0d]", t), int'(thread_free[t*CW +: CW]), ref_free(t));
    check(req, "global_free", int'(global_free), CAP - m_total);
    check(req, "alloc_reject", int'(alloc_reject), int'(m_rej));
  endtask

  task automatic step(string req);
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic idle();
    alloc_valid = 0; retire_valid = 0;
  endtask

  task automatic alloc(int tid, int n, string req);
    for (int i = 0; i < n; i++) begin
      alloc_valid = 1; alloc_tid = TW'(tid); retire_valid = 0;
      step(req);
    end
    idle();
  endtask

  task automatic retire(int tid, int n, string req);
    for (int i = 0; i < n; i++) begin
      retire_valid = 1; retire_tid = TW'(tid); alloc_valid = 0;
      step(req);
    end
    idle();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R1"); step("R1");
    rst = 0; step("R1");
    check("R1", "reset global_free", int'(global_free), CAP);
    check("R1", "reset thread_free[0]", int'(thread_free[0 +: CW]), CAP);
    check("R1", "reset alloc_reject", int'(alloc_reject), 0);

    // R2 shared mode
    active_mask = 4'b1111;
    alloc(0, 5, "R2");
    check("R2", "shared free t0", int'(thread_free[0 +: CW]), 27);
    check("R7", "global after 5", int'(global_free), 27);

    // R9 same-thread alloc+retire
    alloc_valid = 1; alloc_tid = 0; retire_valid = 1; retire_tid = 0;
    step("R9"); idle();
    check("R9", "same-thread pair t0", int'(thread_free[0 +: CW]), 27);
    // different threads in one cycle
    alloc_valid = 1; alloc_tid = 1; retire_valid = 1; retire_tid = 0;
    step("R9"); idle();
    // retire from empty thread is ignored
    retire(3, 1, "R9");
    check("R9", "empty retire global", int'(global_free), 27);

    // R8 fill the global buffer then overflow
    alloc(1, 27, "R8");
    check("R8", "global full", int'(global_free), 0);
    alloc_valid = 1; alloc_tid = 2; step("R8"); idle();
    check("R8", "reject pulse", int'(alloc_reject), 1);
    step("R8");
    check("R8", "reject clears", int'(alloc_reject), 0);
    // full thread: alloc refused while retire on same thread succeeds
    alloc_valid = 1; alloc_tid = 1; retire_valid = 1; retire_tid = 1;
    step("R8"); idle();
    check("R8", "refused+retire global", int'(global_free), 1);
    retire(0, 4, "R7");
    retire(1, 27, "R7");
    check("R7", "drained", int'(global_free), CAP);

    // R3 even split
    cfg_policy = 2'b01; active_mask = 4'b0000; step("R11");
    check("R3", "split empty mask", int'(thread_free[2*CW +: CW]), 8);
    alloc(2, 9, "R3");
    check("R3", "t2 capped", int'(thread_free[2*CW +: CW]), 0);
    check("R8", "9th refused", int'(alloc_reject), 1);
    active_mask = 4'b0011; step("R11");
    check("R3", "two active t0", int'(thread_free[0 +: CW]), 16);
    active_mask = 4'b0111; step("R3");
    check("R3", "three active t0", int'(thread_free[0 +: CW]), 10);
    active_mask = 4'b0011; step("R3");
    alloc(0, 12, "R10");
    active_mask = 4'b1111; step("R10");
    check("R10", "over ceiling t0", int'(thread_free[0 +: CW]), 0);
    retire(0, 5, "R10");
    check("R10", "recovered t0", int'(thread_free[0 +: CW]), 1);
    retire(0, 7, "R10");
    retire(2, 8, "R10");

    // R4 threshold
    cfg_policy = 2'b10; cfg_threshold = 6; active_mask = 4'b1111; step("R4");
    check("R4", "thr t3", int'(thread_free[3*CW +: CW]), 6);
    alloc(3, 7, "R4");
    active_mask = 4'b0100; step("R4");
    check("R4", "single active t2", int'(thread_free[2*CW +: CW]), CAP);
    check("R4", "inactive t3", int'(thread_free[3*CW +: CW]), 0);
    cfg_threshold = 6'd40; active_mask = 4'b1001; step("R4");
    check("R4", "clamped t1", int'(thread_free[CW +: CW]), CAP);
    retire(3, 6, "R4");

    // R5 illegal policy
    cfg_policy = 2'b11; step("R5");
    alloc(0, 2, "R5");
    check("R5", "bad policy reject", int'(alloc_reject), 1);
    check("R5", "bad policy free", int'(thread_free), 0);

    // Random mix, compared every clock
    for (int i = 0; i < 3000; i++) begin
      alloc_valid  = ($urandom % 3) != 0;
      alloc_tid    = TW'($urandom);
      retire_valid = ($urandom % 2) != 0;
      retire_tid   = TW'($urandom);
      if ($urandom % 50 == 0) active_mask = NT'($urandom);
      if ($urandom % 200 == 0) cfg_policy = 2'($urandom);
      if ($urandom % 100 == 0) cfg_threshold = CW'($urandom % 40);
      step("R6");
    end
    idle();
    rst = 1; step("R1"); rst = 0; step("R1");
    check("R1", "second reset global", int'(global_free), CAP);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule